// File: doc/BRIEF.md
# Nonvolatile Byte Array Program/Erase Sequencer

This block governs writes into a small on-chip nonvolatile byte array. The array is modelled as a register file whose bits can only be cleared by programming and set by erasing. A processor reaches the block over a plain strobed bus. It sees one 8-bit control register at `CTRL_ADDR` (0x80 by default) and the array window at addresses 0x00 to `DEPTH-1`.

Software first opens the latch, then writes the target byte and its data, then raises the strobe bit. The operation is committed to the array at the moment the strobe drops. Software can drop the strobe itself. In timed mode an internal counter drops it after a length that depends on the selected operation. A protect input blocks every commit.

The sequencer has five states:
- `ST_IDLE`: latch closed.
- `ST_OPEN`: latch open, no target captured yet.
- `ST_READY`: target captured.
- `ST_BURN_SW`: strobe high, ended by software.
- `ST_BURN_TIMED`: strobe high, ended by the counter.

Its transitions are:
- open: `ST_IDLE`→`ST_OPEN`, on a control write with the latch bit set.
- capture: `ST_OPEN`→`ST_READY`, on an array read or write.
- close: `ST_OPEN`/`ST_READY`→`ST_IDLE`, on a control write with the latch bit clear.
- fire: `ST_READY`→`ST_BURN_SW` or `ST_BURN_TIMED`, on a control write with the strobe bit set. The auto bit of that same write picks the target.
- release: `ST_BURN_SW`→`ST_READY`, on a control write with the strobe bit clear.
- expire: `ST_BURN_TIMED`→`ST_READY`, when the counter ends.

Top module: `nvm_seq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `busy` is 0 and every array byte reads 0xFF.
- R2: Control register bits: 7 spare (read/write, no effect), 6 always reads 0, 5 power-down, 4:3 operation select, 2 latch enable, 1 auto, 0 strobe.
- R3: While the latch is enabled and the strobe is 0, a write to an array address captures that address and data, and a later write replaces both. An array write with the latch disabled changes nothing in the array.
- R4: While the latch is enabled, an array read returns the latched data and replaces the latched address with the read address.
- R5: The strobe bit becomes 1 only if the latch was already enabled before the write and an address has been captured. Otherwise it stays 0.
- R6: A control write that clears both strobe and latch while the strobe is 1 clears only the strobe, and the latch stays enabled.
- R7: When the strobe falls, the latched target is updated according to the operation select value latched when the strobe was set:
  - 00: byte becomes old AND data.
  - 01: byte becomes 0xFF.
  - 10: the 32-byte block selected by address bits 6:5 becomes 0xFF.
  - 11: the whole array becomes 0xFF.
- R8: When `wr_protect` is 1 at the cycle the strobe falls, the array is left unchanged.
- R9: With auto set, the strobe and `busy` stay high for exactly `BYTE_CYC` cycles (selects 00/01), `BLOCK_CYC` cycles (10) or `BULK_CYC` cycles (11), counted from the setting write. Software writes cannot end a timed burn.
- R10: With power-down set and the latch disabled, array reads return 0x00.
- R11: `bus_rdata` is registered. It changes only at the edge where `bus_rd` is sampled high. Reads outside the array and the control register return 0x00, and writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| wr_protect | input | 1 | Blocks every program or erase commit |
| busy | output | 1 | High while the strobe bit is set |

## Verification
Every control and array write takes effect at the clock edge that samples it, and read data is valid after the edge that samples `bus_rd`. The bench therefore drives each access on a falling edge and reads the result 1 ns after the following rising edge. An array commit lands on the same edge as the falling strobe, so the bench reopens the array only after a further write that closes the latch, because an open latch masks the array contents. For timed burns the bench counts post-edge samples with `busy` high, starting with the edge of the setting write. It compares that count with the exact cycle length, including the case where a software write lands in the middle of the burn.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_READY,
        ST_BURN_SW,
        ST_BURN_TIMED
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_PROG        = 2'b00,
        OP_ERASE_BYTE  = 2'b01,
        OP_ERASE_BLOCK = 2'b10,
        OP_ERASE_ALL   = 2'b11
    } op_mode_t;

    // control register bit positions (software-visible encoding)
    localparam int B_SPARE   = 7;
    localparam int B_PDN     = 5;
    localparam int B_MODE_HI = 4;
    localparam int B_MODE_LO = 3;
    localparam int B_LATCH   = 2;
    localparam int B_AUTO    = 1;
    localparam int B_STROBE  = 0;

endpackage

// File: rtl/nvm_burn_timer.sv
module nvm_burn_timer
    import nvm_seq_pkg::*;
#(
    parameter int BYTE_CYC  = 64,
    parameter int BLOCK_CYC = 128,
    parameter int BULK_CYC  = 256
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  op_mode_t start_mode,
    input  logic     run,
    output logic     done
);
    localparam int CW = $clog2(BULK_CYC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        unique case (start_mode)
            OP_PROG, OP_ERASE_BYTE: limit = CW'(BYTE_CYC - 1);
            OP_ERASE_BLOCK:         limit = CW'(BLOCK_CYC - 1);
            OP_ERASE_ALL:           limit = CW'(BULK_CYC - 1);
            default:                limit = CW'(BULK_CYC - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= limit;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);

    // R9: a running count only ever moves down until it finishes
    a_r9_count_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && cnt != '0) |=> (cnt < $past(cnt)));

endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array
    import nvm_seq_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int BLOCK = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic                     blocked,
    input  op_mode_t                 op_mode,
    input  logic [$clog2(DEPTH)-1:0] tgt_addr,
    input  logic [7:0]               tgt_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [7:0]               rd_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int BW = $clog2(BLOCK);

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (commit && !blocked) begin
            unique case (op_mode)
                OP_PROG:       cells[tgt_addr] <= cells[tgt_addr] & tgt_data;
                OP_ERASE_BYTE: cells[tgt_addr] <= 8'hFF;
                OP_ERASE_BLOCK: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if ((AW'(i) >> BW) == (tgt_addr >> BW)) cells[i] <= 8'hFF;
                    end
                end
                OP_ERASE_ALL: begin
                    for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
                end
                default: ;
            endcase
        end
    end

    assign rd_data = cells[rd_addr];

    // R8: a blocked commit leaves the target byte untouched
    a_r8_protect_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && blocked) |=> (cells[$past(tgt_addr)] == $past(cells[tgt_addr])));

    // R7: programming can only clear bits of the target
    a_r7_prog_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !blocked && op_mode == OP_PROG)
            |=> ((cells[$past(tgt_addr)] & ~$past(cells[tgt_addr])) == 8'h00));

endmodule

// File: rtl/nvm_seq_fsm.sv
module nvm_seq_fsm
    import nvm_seq_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          arr_wr,
    input  logic          arr_rd,
    input  logic [AW-1:0] arr_addr,
    input  logic [7:0]    wdata,
    input  logic          timer_done,
    output logic          lat_en,
    output logic          strobe,
    output logic          timer_start,
    output logic          timed_run,
    output logic          commit,
    output op_mode_t      op_mode,
    output logic [AW-1:0] lat_addr,
    output logic [7:0]    lat_data,
    output logic          pdn,
    output logic [7:0]    ctrl_q
);
    seq_state_t state, state_nx;
    logic       spare_q;
    logic       auto_q;
    op_mode_t   mode_q;
    logic       fire;

    // fire transition: strobe accepted only from ST_READY
    assign fire = (state == ST_READY) && ctrl_wr && wdata[B_STROBE];

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ctrl_wr && wdata[B_LATCH]) state_nx = ST_OPEN;
            end
            ST_OPEN: begin
                if (ctrl_wr) begin
                    if (!wdata[B_LATCH]) state_nx = ST_IDLE;
                end else if (arr_wr || arr_rd) begin
                    state_nx = ST_READY;
                end
            end
            ST_READY: begin
                if (fire) begin
                    state_nx = wdata[B_AUTO] ? ST_BURN_TIMED : ST_BURN_SW;
                end else if (ctrl_wr && !wdata[B_LATCH]) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_BURN_SW: begin
                if (ctrl_wr && !wdata[B_STROBE]) state_nx = ST_READY;
            end
            ST_BURN_TIMED: begin
                if (timer_done) state_nx = ST_READY;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare_q  <= 1'b0;
            pdn      <= 1'b0;
            mode_q   <= OP_PROG;
            auto_q   <= 1'b0;
            op_mode  <= OP_PROG;
            lat_addr <= '0;
            lat_data <= '0;
        end else begin
            if (ctrl_wr) begin
                spare_q <= wdata[B_SPARE];
                pdn     <= wdata[B_PDN];
                mode_q  <= op_mode_t'(wdata[B_MODE_HI:B_MODE_LO]);
                auto_q  <= wdata[B_AUTO];
            end
            if (fire) op_mode <= op_mode_t'(wdata[B_MODE_HI:B_MODE_LO]);
            if ((state == ST_OPEN || state == ST_READY) && !ctrl_wr) begin
                if (arr_wr) begin
                    lat_addr <= arr_addr;
                    lat_data <= wdata;
                end else if (arr_rd) begin
                    lat_addr <= arr_addr;
                end
            end
        end
    end

    always_comb begin
        lat_en      = (state != ST_IDLE);
        strobe      = (state == ST_BURN_SW) || (state == ST_BURN_TIMED);
        timed_run   = (state == ST_BURN_TIMED);
        timer_start = fire && wdata[B_AUTO];
        commit      = ((state == ST_BURN_SW) && ctrl_wr && !wdata[B_STROBE])
                   || ((state == ST_BURN_TIMED) && timer_done);
        ctrl_q            = 8'h00;
        ctrl_q[B_SPARE]   = spare_q;
        ctrl_q[B_PDN]     = pdn;
        ctrl_q[B_MODE_HI] = mode_q[1];
        ctrl_q[B_MODE_LO] = mode_q[0];
        ctrl_q[B_LATCH]   = lat_en;
        ctrl_q[B_AUTO]    = auto_q;
        ctrl_q[B_STROBE]  = strobe;
    end

    // R5: the strobe only rises out of a state with a captured address
    a_r5_strobe_interlock: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !$past(strobe)) |-> ($past(state) == ST_READY));

    // R6: a combined clear of strobe and latch keeps the latch open
    a_r6_combined_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURN_SW && ctrl_wr && !wdata[B_STROBE] && !wdata[B_LATCH])
            |=> (lat_en && !strobe));

    // R9: software cannot end a timed burn before the counter does
    a_r9_timed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURN_TIMED && !timer_done) |=> (state == ST_BURN_TIMED));

    // R7: a commit always coincides with the strobe falling
    a_r7_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!strobe && lat_en));

endmodule

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
    import nvm_seq_pkg::*;
#(
    parameter int         DEPTH     = 128,
    parameter int         BLOCK     = 32,
    parameter int         BYTE_CYC  = 64,
    parameter int         BLOCK_CYC = 128,
    parameter int         BULK_CYC  = 256,
    parameter logic [7:0] CTRL_ADDR = 8'h80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_rd,
    input  logic       bus_wr,
    output logic [7:0] bus_rdata,
    input  logic       wr_protect,
    output logic       busy
);
    localparam int AW = $clog2(DEPTH);

    logic          arr_sel, ctrl_sel;
    logic [AW-1:0] arr_addr;
    logic          lat_en, strobe, timer_start, timed_run, commit, timer_done, pdn;
    op_mode_t      op_mode;
    logic [AW-1:0] lat_addr;
    logic [7:0]    lat_data, ctrl_q, cell_rd;

    assign arr_sel  = ({24'd0, bus_addr} < DEPTH);
    assign ctrl_sel = (bus_addr == CTRL_ADDR);
    assign arr_addr = bus_addr[AW-1:0];

    nvm_seq_fsm #(.AW(AW)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (bus_wr && ctrl_sel),
        .arr_wr      (bus_wr && arr_sel),
        .arr_rd      (bus_rd && arr_sel),
        .arr_addr    (arr_addr),
        .wdata       (bus_wdata),
        .timer_done  (timer_done),
        .lat_en      (lat_en),
        .strobe      (strobe),
        .timer_start (timer_start),
        .timed_run   (timed_run),
        .commit      (commit),
        .op_mode     (op_mode),
        .lat_addr    (lat_addr),
        .lat_data    (lat_data),
        .pdn         (pdn),
        .ctrl_q      (ctrl_q)
    );

    nvm_burn_timer #(
        .BYTE_CYC  (BYTE_CYC),
        .BLOCK_CYC (BLOCK_CYC),
        .BULK_CYC  (BULK_CYC)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (timer_start),
        .start_mode (op_mode_t'(bus_wdata[B_MODE_HI:B_MODE_LO])),
        .run        (timed_run),
        .done       (timer_done)
    );

    nvm_cell_array #(.DEPTH(DEPTH), .BLOCK(BLOCK)) array_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .blocked  (wr_protect),
        .op_mode  (op_mode),
        .tgt_addr (lat_addr),
        .tgt_data (lat_data),
        .rd_addr  (arr_addr),
        .rd_data  (cell_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= 8'h00;
        end else if (bus_rd) begin
            if (ctrl_sel)     bus_rdata <= ctrl_q;
            else if (arr_sel) bus_rdata <= lat_en ? lat_data : (pdn ? 8'h00 : cell_rd);
            else              bus_rdata <= 8'h00;
        end
    end

    assign busy = strobe;

    // R4: an array read with the latch open returns the latched byte
    a_r4_read_returns_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && arr_sel && lat_en) |=> (bus_rdata == $past(lat_data)));

    // R11: unmapped reads return zero, and data holds without a read
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !arr_sel && !ctrl_sel) |=> (bus_rdata == 8'h00));
    a_r11_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/nvm_seq_ctrl_tb_top.sv
module nvm_seq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic       wr_protect = 1'b0;
    logic [7:0] bus_rdata;
    logic       busy;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    nvm_seq_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_rdata  (bus_rdata),
        .wr_protect (wr_protect),
        .busy       (busy)
    );

    // vector: {is_read, addr, wdata, expected, requirement}
    localparam int NV = 49;
    localparam logic [28:0] VECS [NV] = '{
        {1'b1, 8'h05, 8'h00, 8'hFF, 4'd1},  // R1 erased after reset
        {1'b0, 8'h80, 8'h04, 8'h00, 4'd2},
        {1'b1, 8'h80, 8'h00, 8'h04, 4'd2},  // R2 latch bit reads back
        {1'b0, 8'h05, 8'h5A, 8'h00, 4'd3},
        {1'b0, 8'h05, 8'h3C, 8'h00, 4'd3},
        {1'b1, 8'h05, 8'h00, 8'h3C, 4'd3},  // R3 later write wins
        {1'b0, 8'h80, 8'h05, 8'h00, 4'd5},
        {1'b1, 8'h80, 8'h00, 8'h05, 4'd5},  // R5 strobe accepted
        {1'b0, 8'h80, 8'h00, 8'h00, 4'd6},
        {1'b1, 8'h80, 8'h00, 8'h04, 4'd6},  // R6 latch survives
        {1'b0, 8'h80, 8'h00, 8'h00, 4'd6},
        {1'b1, 8'h80, 8'h00, 8'h00, 4'd6},  // R6 second write closes latch
        {1'b1, 8'h05, 8'h00, 8'h3C, 4'd7},  // R7 program FF&3C
        {1'b0, 8'h80, 8'h04, 8'h00, 4'd7},
        {1'b0, 8'h05, 8'hF0, 8'h00, 4'd7},
        {1'b0, 8'h80, 8'h05, 8'h00, 4'd7},
        {1'b0, 8'h80, 8'h04, 8'h00, 4'd7},
        {1'b0, 8'h80, 8'h00, 8'h00, 4'd7},
        {1'b1, 8'h05, 8'h00, 8'h30, 4'd7},  // R7 3C&F0
        {1'b0, 8'h80, 8'h04, 8'h00, 4'd4},
        {1'b0, 8'h07, 8'h0F, 8'h00, 4'd4},
        {1'b1, 8'h09, 8'h00, 8'h0F, 4'd4},  // R4 latched data, address 09
        {1'b0, 8'h80, 8'h05, 8'h00, 4'd4},
        {1'b0, 8'h80, 8'h04, 8'h00, 4'd4},
        {1'b0, 8'h80, 8'h00, 8'h00, 4'd4},
        {1'b1, 8'h09, 8'h00, 8'h0F, 4'd4},  // R4 commit went to 09
        {1'b1, 8'h07, 8'h00, 8'hFF, 4'd4},  // R4 07 untouched
        {1'b0, 8'h09, 8'h00, 8'h00, 4'd3},
        {1'b1, 8'h09, 8'h00, 8'h0F, 4'd3},  // R3 write with latch off ignored
        {1'b0, 8'h80, 8'h04, 8'h00, 4'd5},
        {1'b0, 8'h80, 8'h05, 8'h00, 4'd5},
        {1'b1, 8'h80, 8'h00, 8'h04, 4'd5},  // R5 no address captured
        {1'b0, 8'h80, 8'h00, 8'h00, 4'd5},
        {1'b0, 8'h80, 8'h03, 8'h00, 4'd5},
        {1'b1, 8'h80, 8'h00, 8'h02, 4'd5},  // R5 latch not open before
        {1'b0, 8'h80, 8'h00, 8'h00, 4'd5},
        {1'b0, 8'h80, 8'hC0, 8'h00, 4'd2},
        {1'b1, 8'h80, 8'h00, 8'h80, 4'd2},  // R2 spare kept, bit 6 zero
        {1'b0, 8'h80, 8'h20, 8'h00, 4'd10},
        {1'b1, 8'h05, 8'h00, 8'h00, 4'd10}, // R10 powered down
        {1'b0, 8'h80, 8'h00, 8'h00, 4'd10},
        {1'b1, 8'h05, 8'h00, 8'h30, 4'd10}, // R10 content kept
        {1'b0, 8'h80, 8'h0C, 8'h00, 4'd7},
        {1'b0, 8'h05, 8'h77, 8'h00, 4'd7},
        {1'b0, 8'h80, 8'h0D, 8'h00, 4'd7},
        {1'b0, 8'h80, 8'h0C, 8'h00, 4'd7},
        {1'b0, 8'h80, 8'h00, 8'h00, 4'd7},
        {1'b1, 8'h05, 8'h00, 8'hFF, 4'd7},  // R7 byte erase
        {1'b1, 8'h09, 8'h00, 8'h0F, 4'd7}   // R7 neighbour kept
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] q);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        q = bus_rdata;
    endtask

    // counts post-edge samples with busy high, starting with the current one
    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 2000) begin
            n++;
            @(posedge clk); #1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] q;
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R1 busy", busy, 0);
        check("R1 rdata", bus_rdata, 8'h00);
        bus_read(8'h80, q); check("R1 ctrl", q, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][28]) begin
                bus_read(VECS[i][27:20], q);
                check($sformatf("R%0d vec %0d", VECS[i][3:0], i), q, VECS[i][11:4]);
            end else begin
                bus_write(VECS[i][27:20], VECS[i][19:12]);
            end
        end

        // R9 timed byte program: 64 cycles, then commit (R7)
        bus_write(8'h80, 8'h06);
        bus_write(8'h45, 8'h81);
        bus_write(8'h80, 8'h07);
        count_busy(n); check("R9 byte length", n, 64);
        bus_read(8'h80, q); check("R9 strobe auto-cleared", q, 8'h06);
        bus_write(8'h80, 8'h00);
        bus_read(8'h45, q); check("R7 timed program", q, 8'h81);

        // R9 timed block erase, software clear attempt mid-burn
        bus_write(8'h80, 8'h16);
        bus_write(8'h50, 8'h00);
        bus_write(8'h80, 8'h17);
        bus_write(8'h80, 8'h14);
        check("R9 sw clear ignored", busy, 1);
        count_busy(n); check("R9 block length", n + 1, 128);
        bus_read(8'h80, q); check("R9 after block", q, 8'h14);
        bus_write(8'h80, 8'h00);
        bus_read(8'h45, q); check("R7 block erased", q, 8'hFF);
        bus_read(8'h09, q); check("R7 other block kept", q, 8'h0F);

        // R8 protected bulk erase
        wr_protect = 1'b1;
        bus_write(8'h80, 8'h1E);
        bus_write(8'h09, 8'h00);
        bus_write(8'h80, 8'h1F);
        count_busy(n); check("R9 bulk length", n, 256);
        bus_write(8'h80, 8'h00);
        bus_read(8'h09, q); check("R8 protected", q, 8'h0F);
        wr_protect = 1'b0;

        // R7 bulk erase unprotected
        bus_write(8'h80, 8'h1E);
        bus_write(8'h09, 8'h00);
        bus_write(8'h80, 8'h1F);
        count_busy(n);
        bus_write(8'h80, 8'h00);
        bus_read(8'h09, q); check("R7 bulk 09", q, 8'hFF);
        bus_read(8'h7F, q); check("R7 bulk 7F", q, 8'hFF);

        // R11 unmapped space and hold
        bus_write(8'h90, 8'h55);
        bus_read(8'h90, q); check("R11 unmapped read", q, 8'h00);
        bus_read(8'h80, q); check("R11 unmapped write ignored", q, 8'h00);
        bus_read(8'h05, q);
        repeat (3) @(posedge clk); #1;
        check("R11 rdata held", bus_rdata, 8'hFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule